// File: doc/BRIEF.md
# Word Shift and Rotate Unit

This block moves the bits of an N-bit word left or right by a variable distance in a single combinational pass. It can fill the vacated positions in three ways. Zero fill gives the logical shifts. Sign fill copies the original top bit, for the arithmetic right shift. Wraparound fill gives the rotates, where the bits pushed out of one end re-enter at the other.

A 3-bit operation code picks the behaviour. The distance input is log2(N) bits wide, so every distance it can carry is below the word width. There is no clock, no flag and no carry-out.

Each output bit is produced by its own selection multiplexer. The distance drives the select of that multiplexer. The operation code decides which candidate bit sits at each multiplexer input.

Top module: `wordshift_unit`

## Requirements
- R1: With op_i = 3'b000, y_o equals a_i moved left by amt_i places, with the low amt_i bits of y_o set to 0.
- R2: With op_i = 3'b001, y_o equals a_i moved right by amt_i places, with the high amt_i bits of y_o set to 0.
- R3: With op_i = 3'b010, y_o equals a_i moved right by amt_i places, with the high amt_i bits of y_o set to bit N-1 of a_i.
- R4: With op_i = 3'b011, y_o is identical to the R1 result for the same a_i and amt_i.
- R5: With op_i = 3'b100, y_o equals a_i rotated left by amt_i places: bit i of y_o is bit (i - amt_i) mod N of a_i.
- R6: With op_i = 3'b101, y_o equals a_i rotated right by amt_i places: bit i of y_o is bit (i + amt_i) mod N of a_i.
- R7: With op_i = 3'b110 or 3'b111, y_o equals a_i and amt_i has no effect.
- R8: With amt_i = 0, y_o equals a_i for every op_i value.
- R9: For any amt_i k > 0, rotating left by k gives the same y_o as rotating right by N - k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Word to be shifted or rotated |
| amt_i | input | log2(N) | Distance in bit places |
| op_i | input | 3 | Operation code (see R1 to R7) |
| y_o | output | N | Result word |

## Verification
All six operation codes and both pass-through codes are swept over every distance from 0 to N-1.

Several patterns are used, and each exposes a different fault:
- A single walking one shows whether a bit lands in the wrong position.
- An all-ones word and words whose top bit is set tell sign fill apart from zero fill.
- Mixed patterns that repeat neither the top nor the bottom bit show when wraparound bits are taken from the wrong end.
- Scaled versions of the 11001 example check the distance-2 results of each fill kind.
- Pairs of rotates by k and by N - k show that left and right wraparound agree.

// File: rtl/wordshift_pkg.sv
package wordshift_pkg;

    typedef enum logic [2:0] {
        OP_SLL  = 3'b000,
        OP_SRL  = 3'b001,
        OP_SRA  = 3'b010,
        OP_SLA  = 3'b011,
        OP_ROL  = 3'b100,
        OP_ROR  = 3'b101,
        OP_PAS0 = 3'b110,
        OP_PAS1 = 3'b111
    } shift_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  go_left;
        fill_e fill;
        logic  bypass;
    } shift_ctl_t;

    function automatic shift_ctl_t decode_op(shift_op_e op);
        shift_ctl_t c;
        c.go_left = 1'b0;
        c.fill    = FILL_ZERO;
        c.bypass  = 1'b0;
        unique case (op)
            OP_SLL, OP_SLA: c.go_left = 1'b1;
            OP_SRL:         c.go_left = 1'b0;
            OP_SRA:         c.fill    = FILL_SIGN;
            OP_ROL: begin
                c.go_left = 1'b1;
                c.fill    = FILL_WRAP;
            end
            OP_ROR:         c.fill    = FILL_WRAP;
            default:        c.bypass  = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wordshift_decode.sv
module wordshift_decode
    import wordshift_pkg::*;
(
    input  logic [2:0] op_i,
    output shift_ctl_t ctl_o
);
    shift_op_e op_e;

    always_comb begin
        op_e  = shift_op_e'(op_i);
        ctl_o = decode_op(op_e);
    end

    // Only the wraparound ops may select wrap fill; only op 010 selects sign fill.
    always_comb begin
        if (ctl_o.fill == FILL_SIGN)
            p_sign_only_sra_r3: assert (op_i == 3'b010);
        if (ctl_o.bypass)
            p_bypass_codes_r7: assert (op_i[2:1] == 2'b11);
    end
endmodule

// File: rtl/wordshift_bit_mux.sv
module wordshift_bit_mux
    import wordshift_pkg::*;
#(
    parameter int N   = 32,
    parameter int IDX = 0,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  a_i,
    input  logic [AW-1:0] amt_i,
    input  shift_ctl_t    ctl_i,
    output logic          bit_o
);
    logic [N-1:0] left_cand;
    logic [N-1:0] right_cand;
    logic         wrap;
    logic         right_fill;

    assign wrap       = (ctl_i.fill == FILL_WRAP);
    assign right_fill = (ctl_i.fill == FILL_SIGN) ? a_i[N-1] : 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_cand
        if (IDX >= k) begin : g_l_in
            assign left_cand[k] = a_i[IDX-k];
        end else begin : g_l_out
            assign left_cand[k] = wrap ? a_i[IDX-k+N] : 1'b0;
        end
        if (IDX + k < N) begin : g_r_in
            assign right_cand[k] = a_i[IDX+k];
        end else begin : g_r_out
            assign right_cand[k] = wrap ? a_i[IDX+k-N] : right_fill;
        end
    end

    always_comb begin
        if (ctl_i.bypass)
            bit_o = a_i[IDX];
        else if (ctl_i.go_left)
            bit_o = left_cand[amt_i];
        else
            bit_o = right_cand[amt_i];
    end
endmodule

// File: rtl/wordshift_unit.sv
module wordshift_unit
    import wordshift_pkg::*;
#(
    parameter int N   = 32,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  a_i,
    input  logic [AW-1:0] amt_i,
    input  logic [2:0]    op_i,
    output logic [N-1:0]  y_o
);
    shift_ctl_t ctl;

    wordshift_decode u_decode (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    for (genvar i = 0; i < N; i++) begin : g_bit
        wordshift_bit_mux #(
            .N   (N),
            .IDX (i)
        ) u_mux (
            .a_i   (a_i),
            .amt_i (amt_i),
            .ctl_i (ctl),
            .bit_o (y_o[i])
        );
    end

    // Reference views of the port relations
    logic [2*N-1:0] dbl_l;
    logic [2*N-1:0] dbl_r;
    logic [N-1:0]   rol_ref;
    logic [N-1:0]   ror_ref;

    always_comb begin
        dbl_l   = {a_i, a_i} << amt_i;
        dbl_r   = {a_i, a_i} >> amt_i;
        rol_ref = dbl_l[2*N-1:N];
        ror_ref = dbl_r[N-1:0];
        if (op_i == 3'b000)
            p_sll_zero_fill_r1: assert (y_o == (a_i << amt_i));
        if (op_i == 3'b001)
            p_srl_zero_fill_r2: assert (y_o == (a_i >> amt_i));
        if (op_i == 3'b010)
            p_sra_sign_fill_r3: assert (y_o == N'($signed(a_i) >>> amt_i));
        if (op_i == 3'b011)
            p_sla_as_sll_r4: assert (y_o == (a_i << amt_i));
        if (op_i == 3'b100)
            p_rol_wrap_r5: assert (y_o == rol_ref);
        if (op_i == 3'b101)
            p_ror_wrap_r6: assert (y_o == ror_ref);
        if (op_i[2:1] == 2'b11)
            p_pass_codes_r7: assert (y_o == a_i);
        if (amt_i == '0)
            p_zero_amount_r8: assert (y_o == a_i);
    end
endmodule

// File: tb/wordshift_unit_bench.sv
module wordshift_unit_bench;
    localparam int N  = 32;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic [N-1:0]  a;
    logic [AW-1:0] amt;
    logic [2:0]    op;
    logic [N-1:0]  y;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    wordshift_unit #(.N(N)) u_wordshift_unit (
        .a_i   (a),
        .amt_i (amt),
        .op_i  (op),
        .y_o   (y)
    );

    // Independent bit-by-bit model of the requirements
    function automatic logic [N-1:0] model(logic [N-1:0] w, int s, logic [2:0] o);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            int src;
            case (o)
                3'b000, 3'b011: begin
                    src  = i - s;
                    r[i] = (src >= 0) ? w[src] : 1'b0;
                end
                3'b001: begin
                    src  = i + s;
                    r[i] = (src < N) ? w[src] : 1'b0;
                end
                3'b010: begin
                    src  = i + s;
                    r[i] = (src < N) ? w[src] : w[N-1];
                end
                3'b100: r[i] = w[(i - s + N) % N];
                3'b101: r[i] = w[(i + s) % N];
                default: r[i] = w[i];
            endcase
        end
        return r;
    endfunction

    task automatic apply(input logic [N-1:0] w, input int s, input logic [2:0] o);
        @(negedge clk);
        a   = w;
        amt = AW'(s);
        op  = o;
        #1;
    endtask

    task automatic expect_y(input logic [N-1:0] exp, input string req);
        checks++;
        if (y !== exp) begin
            fails++;
            $display("FAIL %s: a=%h amt=%0d op=%b actual=%h expected=%h",
                     req, a, amt, op, y, exp);
        end
    endtask

    task automatic sweep(input logic [N-1:0] w, input logic [2:0] o, input string req);
        for (int s = 0; s < N; s++) begin
            apply(w, s, o);
            expect_y(model(w, s, o), req);
        end
    endtask

    task automatic t_idle;
        apply('0, 0, 3'b000);
        expect_y('0, "R8 idle");
    endtask

    task automatic t_sll_r1;
        apply(32'hC800_0019, 2, 3'b000);
        expect_y(32'h2000_0064, "R1 example");
        sweep(32'h0000_0001, 3'b000, "R1");
        sweep(32'hA5C3_0F96, 3'b000, "R1");
    endtask

    task automatic t_srl_r2;
        apply(32'hC800_0000, 2, 3'b001);
        expect_y(32'h3200_0000, "R2 example");
        sweep(32'h8000_0000, 3'b001, "R2");
        sweep(32'hFFFF_FFFF, 3'b001, "R2");
    endtask

    task automatic t_sra_r3;
        apply(32'hC800_0000, 2, 3'b010);
        expect_y(32'hF200_0000, "R3 example");
        apply(32'h7FFF_FFFF, 31, 3'b010);
        expect_y(32'h0000_0000, "R3 positive");
        sweep(32'h8000_0001, 3'b010, "R3");
        sweep(32'h4A5C_3F96, 3'b010, "R3");
    endtask

    task automatic t_sla_r4;
        sweep(32'hA5C3_0F96, 3'b011, "R4");
        apply(32'hFFFF_FFFF, 31, 3'b011);
        expect_y(32'h8000_0000, "R4 edge");
    endtask

    task automatic t_rol_r5;
        apply(32'hC800_0000, 2, 3'b100);
        expect_y(32'h2000_0003, "R5 example");
        sweep(32'h8000_0000, 3'b100, "R5");
        sweep(32'h1234_5678, 3'b100, "R5");
    endtask

    task automatic t_ror_r6;
        apply(32'h0000_0019, 2, 3'b101);
        expect_y(32'h4000_0006, "R6 example");
        sweep(32'h0000_0001, 3'b101, "R6");
        sweep(32'h1234_5678, 3'b101, "R6");
    endtask

    task automatic t_pass_r7;
        sweep(32'hDEAD_BEEF, 3'b110, "R7");
        sweep(32'h0F0F_3C3C, 3'b111, "R7");
    endtask

    task automatic t_zero_r8;
        for (int o = 0; o < 8; o++) begin
            apply(32'h9E37_79B9, 0, 3'(o));
            expect_y(32'h9E37_79B9, "R8");
        end
    endtask

    task automatic t_rot_pair_r9;
        for (int k = 1; k < N; k++) begin
            logic [N-1:0] left_res;
            apply(32'hC0DE_1357, k, 3'b100);
            left_res = y;
            apply(32'hC0DE_1357, N - k, 3'b101);
            expect_y(left_res, "R9");
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        a   = '0;
        amt = '0;
        op  = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_sll_r1();
        t_srl_r2();
        t_sra_r3();
        t_sla_r4();
        t_rol_r5();
        t_ror_r6();
        t_pass_r7();
        t_zero_r8();
        t_rot_pair_r9();
        finish_run();
    end
endmodule